// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block is the thread-selection front of a fine-grained multithreaded core. Each live thread owns one status word, holding its thread id and program counter. Every cycle the word at the front of a ready queue issues that thread's next instruction. The surrounding pipeline then reports whether the instruction touches memory.

A compute instruction sends the word, with its counter advanced, through a fixed-length circulation pipe and back into the ready queue. Because of this, a thread never has two instructions in flight and needs no forwarding or interlocks. A memory instruction instead takes the word out of circulation and parks it per thread. A memory request is raised with the thread tag. The word rejoins the ready queue only when the response carrying that tag comes back.

Threads are started and stopped by spawn and retire commands.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is held and in the cycles after its release with no thread spawned, `issue_valid` and `mem_req_valid` are both 0.
- R2: In a cycle in which the ready queue holds no live word, `issue_valid` is 0 (a bubble).
- R3: A thread running compute instructions alone issues again exactly `LOOP_DEPTH` cycles after each issue, with its PC one higher (modulo 2^`PC_W`). A thread never issues in two consecutive cycles.
- R4: Words leave the ready queue in arrival order. With `LOOP_DEPTH` compute-only threads spawned in consecutive cycles, every cycle issues, and each thread takes exactly one slot in every `LOOP_DEPTH` cycles.
- R5: When `issue_mem_op` is 1 in an issue cycle, `mem_req_valid` is 1 in that same cycle with `mem_req_tid`/`mem_req_pc` equal to the issued thread and PC. The thread then issues nothing until a response carrying its tag arrives.
- R6: A response for a parked live thread, presented in cycle r, makes that thread issue in cycle r+1 (if nothing is ahead of it) at the PC after the memory instruction.
- R7: When a response and a word finishing its circulation arrive in the same cycle, the response word is queued ahead. Both are queued, and neither is lost.
- R8: A spawn command in cycle c for a thread with no word anywhere in the block makes it issue at the given PC in cycle c+1 (if the queue was empty). A spawn for a thread that still has a word anywhere is ignored.
- R9: After a retire command in cycle c for a circulating or queued thread, that thread issues nothing from cycle c+1 on. Its id becomes free once its word is dropped.
- R10: A retire aimed at a thread parked on memory takes effect when its response arrives. That response is discarded and produces no issue, and the id is free for a spawn from the following cycle.
- R11: A response whose tag names a thread that is not parked is ignored and causes no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_valid | input | 1 | Start a thread this cycle |
| spawn_tid | input | TID_W | Thread to start |
| spawn_pc | input | PC_W | First PC of the started thread |
| retire_valid | input | 1 | Stop a thread this cycle |
| retire_tid | input | TID_W | Thread to stop |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Thread of the issued instruction |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_mem_op | input | 1 | Same-cycle class of the issued instruction: 1 for memory, 0 for compute |
| mem_req_valid | output | 1 | A memory request leaves this cycle |
| mem_req_tid | output | TID_W | Tag of the memory request |
| mem_req_pc | output | PC_W | PC of the memory instruction |
| mem_rsp_valid | input | 1 | A memory response arrives this cycle |
| mem_rsp_tid | input | TID_W | Tag of the memory response |

## Verification
The two enqueue sources that can collide are a memory response and a word returning from circulation. The bench provokes the collision by parking one thread on a memory instruction while a second thread circulates. It then returns the response in exactly the cycle the second thread's word finishes its trip. The collision is judged from the issue stream: the responding thread must take the next slot, and the circulating thread the slot after. Each thread's following issue must then land a full loop later. A retire that overlaps a pending response is also checked, by confirming that no issue appears when the response arrives and that the freed id can be spawned right after.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    // Enqueue sources of the ready queue, in queue-order priority:
    // a memory response is written ahead of a circulation return,
    // which is written ahead of a freshly spawned thread.
    typedef enum logic [1:0] {
        PUSH_RSP  = 2'd0,
        PUSH_LOOP = 2'd1,
        PUSH_NEW  = 2'd2
    } push_src_e;

    localparam int NUM_PUSH = 3;

endpackage

// File: rtl/barrel_ready_queue.sv
module barrel_ready_queue
    import barrel_pkg::*;
#(
    parameter int DEPTH = 120,
    parameter int W     = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PUSH-1:0]          push_valid,
    input  logic [NUM_PUSH-1:0][W-1:0]   push_word,
    input  logic                         pop,
    output logic                         head_valid,
    output logic [W-1:0]                 head_word
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } rq_state_t;

    rq_state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    logic             do_pop;
    logic [PTR_W-1:0] wp;
    logic [CNT_W-1:0] added;

    always_comb begin
        st_d   = st_q;
        wp     = st_q.wr;
        added  = '0;
        do_pop = pop && (st_q.cnt != '0);
        // pushes are packed into consecutive slots in source priority order
        for (int k = 0; k < NUM_PUSH; k++) begin
            if (push_valid[k]) begin
                st_d.mem[wp] = push_word[k];
                wp           = ring_next(wp);
                added        = CNT_W'(added + 1'b1);
            end
        end
        st_d.wr = wp;
        if (do_pop) begin
            st_d.rd = ring_next(st_q.rd);
        end
        st_d.cnt = CNT_W'(st_q.cnt + added - CNT_W'(do_pop));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_word  = st_q.mem[st_q.rd];

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/barrel_loop_pipe.sv
module barrel_loop_pipe #(
    parameter int STAGES = 7,
    parameter int W      = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    output logic         out_valid,
    output logic [W-1:0] out_word
);

    typedef struct packed {
        logic [STAGES-1:0]        v;
        logic [STAGES-1:0][W-1:0] w;
    } lp_state_t;

    lp_state_t lp_q, lp_d;

    always_comb begin
        lp_d      = lp_q;
        lp_d.v[0] = in_valid;
        lp_d.w[0] = in_word;
        for (int s = 1; s < STAGES; s++) begin
            lp_d.v[s] = lp_q.v[s-1];
            lp_d.w[s] = lp_q.w[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_q <= '0;
        end else begin
            lp_q <= lp_d;
        end
    end

    assign out_valid = lp_q.v[STAGES-1];
    assign out_word  = lp_q.w[STAGES-1];

endmodule

// File: rtl/barrel_ctx_table.sv
module barrel_ctx_table #(
    parameter int NT    = 120,
    parameter int TID_W = 7,
    parameter int PC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [TID_W-1:0] head_tid,
    output logic             head_live,
    input  logic             issue_fire,
    input  logic             issue_is_mem,
    input  logic [TID_W-1:0] issue_tid,
    input  logic [PC_W-1:0]  issue_pc,
    input  logic             exit_valid,
    input  logic [TID_W-1:0] exit_tid,
    output logic             exit_live,
    input  logic             rsp_valid,
    input  logic [TID_W-1:0] rsp_tid,
    output logic             rsp_push,
    output logic [PC_W-1:0]  rsp_pc,
    input  logic             new_valid,
    input  logic [TID_W-1:0] new_tid,
    output logic             new_ok,
    input  logic             kill_valid,
    input  logic [TID_W-1:0] kill_tid
);

    typedef struct packed {
        logic [NT-1:0]            alive;
        logic [NT-1:0]            present;
        logic [NT-1:0]            parked;
        logic [NT-1:0][PC_W-1:0]  park_pc;
    } ct_state_t;

    ct_state_t ct_q, ct_d;
    logic      rsp_hit;

    always_comb begin
        ct_d      = ct_q;
        head_live = ct_q.alive[head_tid];
        exit_live = ct_q.alive[exit_tid];
        rsp_hit   = rsp_valid && ct_q.parked[rsp_tid];
        rsp_push  = rsp_hit && ct_q.alive[rsp_tid];
        rsp_pc    = ct_q.park_pc[rsp_tid];
        new_ok    = new_valid && !ct_q.present[new_tid];

        // retire only marks the thread; its word is dropped where it surfaces
        if (kill_valid && ct_q.present[kill_tid]) begin
            ct_d.alive[kill_tid] = 1'b0;
        end
        if (head_valid && !head_live) begin
            ct_d.present[head_tid] = 1'b0;
        end
        if (exit_valid && !exit_live) begin
            ct_d.present[exit_tid] = 1'b0;
        end
        if (issue_fire && issue_is_mem) begin
            ct_d.parked[issue_tid]  = 1'b1;
            ct_d.park_pc[issue_tid] = PC_W'(issue_pc + 1'b1);
        end
        if (rsp_hit) begin
            ct_d.parked[rsp_tid] = 1'b0;
            if (!ct_q.alive[rsp_tid]) begin
                ct_d.present[rsp_tid] = 1'b0;
            end
        end
        if (new_ok) begin
            ct_d.alive[new_tid]   = 1'b1;
            ct_d.present[new_tid] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    // R5
    parked_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> !ct_q.parked[issue_tid]);

    // R9
    exit_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> ct_q.present[exit_tid]);

    // R8
    spawn_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_ok |=> (ct_q.present[$past(new_tid)] && ct_q.alive[$past(new_tid)]));

    // R6
    rsp_unpark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |=> !ct_q.parked[$past(rsp_tid)]);

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import barrel_pkg::*;
#(
    parameter int NUM_THREADS = 120,
    parameter int LOOP_DEPTH  = 8,
    parameter int PC_W        = 16,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spawn_valid,
    input  logic [TID_W-1:0] spawn_tid,
    input  logic [PC_W-1:0]  spawn_pc,
    input  logic             retire_valid,
    input  logic [TID_W-1:0] retire_tid,
    output logic             issue_valid,
    output logic [TID_W-1:0] issue_tid,
    output logic [PC_W-1:0]  issue_pc,
    input  logic             issue_mem_op,
    output logic             mem_req_valid,
    output logic [TID_W-1:0] mem_req_tid,
    output logic [PC_W-1:0]  mem_req_pc,
    input  logic             mem_rsp_valid,
    input  logic [TID_W-1:0] mem_rsp_tid
);

    localparam int WORD_W    = TID_W + PC_W;
    // the ready-queue register is the last stage of the loop
    localparam int PIPE_REGS = LOOP_DEPTH - 1;

    logic                               head_valid;
    logic [WORD_W-1:0]                  head_word;
    logic [TID_W-1:0]                   head_tid;
    logic [PC_W-1:0]                    head_pc;
    logic                               head_live;
    logic                               loop_in_valid;
    logic [WORD_W-1:0]                  loop_in_word;
    logic                               exit_valid;
    logic [WORD_W-1:0]                  exit_word;
    logic                               exit_live;
    logic                               rsp_push;
    logic [PC_W-1:0]                    rsp_pc;
    logic                               new_ok;
    logic [NUM_PUSH-1:0]                push_valid;
    logic [NUM_PUSH-1:0][WORD_W-1:0]    push_word;

    assign head_tid = head_word[WORD_W-1:PC_W];
    assign head_pc  = head_word[PC_W-1:0];

    assign issue_valid = head_valid && head_live;
    assign issue_tid   = head_tid;
    assign issue_pc    = head_pc;

    assign mem_req_valid = issue_valid && issue_mem_op;
    assign mem_req_tid   = head_tid;
    assign mem_req_pc    = head_pc;

    assign loop_in_valid = issue_valid && !issue_mem_op;
    assign loop_in_word  = {head_tid, PC_W'(head_pc + 1'b1)};

    always_comb begin
        push_valid            = '0;
        push_word             = '0;
        push_valid[PUSH_RSP]  = rsp_push;
        push_word[PUSH_RSP]   = {mem_rsp_tid, rsp_pc};
        push_valid[PUSH_LOOP] = exit_valid && exit_live;
        push_word[PUSH_LOOP]  = exit_word;
        push_valid[PUSH_NEW]  = new_ok;
        push_word[PUSH_NEW]   = {spawn_tid, spawn_pc};
    end

    barrel_ready_queue #(
        .DEPTH (NUM_THREADS),
        .W     (WORD_W)
    ) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_word  (push_word),
        .pop        (head_valid),
        .head_valid (head_valid),
        .head_word  (head_word)
    );

    barrel_loop_pipe #(
        .STAGES (PIPE_REGS),
        .W      (WORD_W)
    ) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (loop_in_valid),
        .in_word   (loop_in_word),
        .out_valid (exit_valid),
        .out_word  (exit_word)
    );

    barrel_ctx_table #(
        .NT    (NUM_THREADS),
        .TID_W (TID_W),
        .PC_W  (PC_W)
    ) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid   (head_valid),
        .head_tid     (head_tid),
        .head_live    (head_live),
        .issue_fire   (issue_valid),
        .issue_is_mem (issue_mem_op),
        .issue_tid    (head_tid),
        .issue_pc     (head_pc),
        .exit_valid   (exit_valid),
        .exit_tid     (exit_word[WORD_W-1:PC_W]),
        .exit_live    (exit_live),
        .rsp_valid    (mem_rsp_valid),
        .rsp_tid      (mem_rsp_tid),
        .rsp_push     (rsp_push),
        .rsp_pc       (rsp_pc),
        .new_valid    (spawn_valid),
        .new_tid      (spawn_tid),
        .new_ok       (new_ok),
        .kill_valid   (retire_valid),
        .kill_tid     (retire_tid)
    );

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !issue_valid && !mem_req_valid);

endmodule

// File: tb/barrel_issue_sched_tb_top.sv
module barrel_issue_sched_tb_top;

    localparam int NT  = 120;
    localparam int LD  = 8;
    localparam int PCW = 16;
    localparam int TW  = $clog2(NT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spawn_valid = 1'b0;
    logic [TW-1:0] spawn_tid = '0;
    logic [PCW-1:0] spawn_pc = '0;
    logic          retire_valid = 1'b0;
    logic [TW-1:0] retire_tid = '0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [PCW-1:0] issue_pc;
    logic          issue_mem_op;
    logic          mem_req_valid;
    logic [TW-1:0] mem_req_tid;
    logic [PCW-1:0] mem_req_pc;
    logic          mem_rsp_valid = 1'b0;
    logic [TW-1:0] mem_rsp_tid = '0;

    logic [NT-1:0]          mem_en = '0;
    logic [NT-1:0][PCW-1:0] mem_pc = '0;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int    at;
        int    tid;
        int    pc;
        bit    mem;
        string req;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // instruction class seen by the issue stage: memory at one chosen PC per thread
    assign issue_mem_op = issue_valid && mem_en[issue_tid] && (issue_pc == mem_pc[issue_tid]);

    barrel_issue_sched #(
        .NUM_THREADS (NT),
        .LOOP_DEPTH  (LD),
        .PC_W        (PCW)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .spawn_valid   (spawn_valid),
        .spawn_tid     (spawn_tid),
        .spawn_pc      (spawn_pc),
        .retire_valid  (retire_valid),
        .retire_tid    (retire_tid),
        .issue_valid   (issue_valid),
        .issue_tid     (issue_tid),
        .issue_pc      (issue_pc),
        .issue_mem_op  (issue_mem_op),
        .mem_req_valid (mem_req_valid),
        .mem_req_tid   (mem_req_tid),
        .mem_req_pc    (mem_req_pc),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_tid   (mem_rsp_tid)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // monitor: every issue is compared with the front of the scoreboard
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2", "unexpected issue tid", int'(issue_tid), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cyc == e.at, e.req, "issue cycle", cyc, e.at);
                check(int'(issue_tid) == e.tid, e.req, "issue tid", int'(issue_tid), e.tid);
                check(int'(issue_pc) == e.pc, e.req, "issue pc", int'(issue_pc), e.pc);
                check(mem_req_valid == e.mem, e.req, "mem request", int'(mem_req_valid), int'(e.mem));
                if (e.mem) begin
                    check(int'(mem_req_tid) == e.tid, e.req, "mem tag", int'(mem_req_tid), e.tid);
                    check(int'(mem_req_pc) == e.pc, e.req, "mem pc", int'(mem_req_pc), e.pc);
                end
            end
        end
    end

    task automatic at_cycle(int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_issue(int at, int tid, int pc, bit mem, string req);
        exp_t e;
        e.at = at; e.tid = tid; e.pc = pc; e.mem = mem; e.req = req;
        expq.push_back(e);
    endtask

    task automatic spawn(int tid, int pc);
        spawn_valid = 1'b1; spawn_tid = TW'(tid); spawn_pc = PCW'(pc);
        @(posedge clk); #1;
        spawn_valid = 1'b0;
    endtask

    task automatic retire(int tid);
        retire_valid = 1'b1; retire_tid = TW'(tid);
        @(posedge clk); #1;
        retire_valid = 1'b0;
    endtask

    task automatic respond(int tid);
        mem_rsp_valid = 1'b1; mem_rsp_tid = TW'(tid);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
    endtask

    task automatic drain(string req);
        check(expq.size() == 0, req, "issues still expected", expq.size(), 0);
        expq.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        spawn_valid = 1'b0; retire_valid = 1'b0; mem_rsp_valid = 1'b0;
        mem_en = '0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 100000);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int c;
        // R1: held reset and quiet cycles after release
        @(negedge clk);
        check(!issue_valid && !mem_req_valid, "R1", "outputs in reset", int'(issue_valid), 0);
        do_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!issue_valid, "R1", "issue after reset", int'(issue_valid), 0);
            check(!mem_req_valid, "R1", "mem request after reset", int'(mem_req_valid), 0);
        end

        // R3 / R8: lone compute thread, duplicate spawn ignored
        c = cyc + 1;
        expect_issue(c + 1, 5, 100, 1'b0, "R8");
        expect_issue(c + 9, 5, 101, 1'b0, "R3");
        expect_issue(c + 17, 5, 102, 1'b0, "R3");
        expect_issue(c + 25, 5, 103, 1'b0, "R8");
        at_cycle(c);
        spawn(5, 100);
        at_cycle(c + 12);
        @(negedge clk);
        check(!issue_valid, "R2", "bubble with empty queue", int'(issue_valid), 0);
        at_cycle(c + 20);
        spawn(5, 999);
        at_cycle(c + 30);
        drain("R3");
        do_reset();

        // R4: full rotation, one slot per thread every LD cycles
        c = cyc + 1;
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < LD; k++) begin
                expect_issue(c + 1 + k + LD * r, k, 10 * k + r, 1'b0, "R4");
            end
        end
        at_cycle(c);
        for (int k = 0; k < LD; k++) spawn(k, 10 * k);
        at_cycle(c + 33);
        drain("R4");
        do_reset();

        // R5 / R6: memory instruction parks the thread until its response
        c = cyc + 1;
        mem_en[3] = 1'b1; mem_pc[3] = PCW'(200);
        expect_issue(c + 1, 3, 200, 1'b1, "R5");
        expect_issue(c + 22, 3, 201, 1'b0, "R6");
        expect_issue(c + 30, 3, 202, 1'b0, "R6");
        at_cycle(c);
        spawn(3, 200);
        at_cycle(c + 21);
        respond(3);
        at_cycle(c + 31);
        drain("R6");
        do_reset();

        // R7: response and circulation return in the same cycle
        c = cyc + 1;
        mem_en[2] = 1'b1; mem_pc[2] = PCW'(50);
        expect_issue(c + 1, 1, 0, 1'b0, "R7");
        expect_issue(c + 2, 2, 50, 1'b1, "R5");
        expect_issue(c + 9, 2, 51, 1'b0, "R7");
        expect_issue(c + 10, 1, 1, 1'b0, "R7");
        expect_issue(c + 17, 2, 52, 1'b0, "R7");
        expect_issue(c + 18, 1, 2, 1'b0, "R7");
        at_cycle(c);
        spawn(1, 0);
        spawn(2, 50);
        at_cycle(c + 8);
        respond(2);
        at_cycle(c + 19);
        drain("R7");
        do_reset();

        // R9: retire of a circulating thread, then its id is reused
        c = cyc + 1;
        expect_issue(c + 1, 4, 0, 1'b0, "R9");
        expect_issue(c + 9, 4, 1, 1'b0, "R9");
        expect_issue(c + 32, 4, 500, 1'b0, "R8");
        at_cycle(c);
        spawn(4, 0);
        at_cycle(c + 10);
        retire(4);
        at_cycle(c + 17);
        @(negedge clk);
        check(!issue_valid, "R9", "issue after retire", int'(issue_valid), 0);
        at_cycle(c + 25);
        @(negedge clk);
        check(!issue_valid, "R9", "issue after retire", int'(issue_valid), 0);
        at_cycle(c + 31);
        spawn(4, 500);
        at_cycle(c + 34);
        drain("R9");
        do_reset();

        // R10 / R11: stray response ignored, retire while parked
        c = cyc + 1;
        mem_en[6] = 1'b1; mem_pc[6] = PCW'(300);
        expect_issue(c + 1, 6, 300, 1'b1, "R10");
        expect_issue(c + 13, 6, 700, 1'b0, "R10");
        at_cycle(c);
        spawn(6, 300);
        at_cycle(c + 3);
        respond(9);
        @(negedge clk);
        check(!issue_valid, "R11", "issue from stray response", int'(issue_valid), 0);
        at_cycle(c + 5);
        retire(6);
        at_cycle(c + 10);
        respond(6);
        @(negedge clk);
        check(!issue_valid, "R10", "issue from discarded response", int'(issue_valid), 0);
        at_cycle(c + 12);
        spawn(6, 700);
        at_cycle(c + 15);
        drain("R10");

        summary();
        $finish;
    end

endmodule